// File: doc/BRIEF.md
# Two-Stage System Clock Prescaler

This block derives two clock-enable streams from a single main clock for a small microcontroller. A prescale stage divides the main clock by 1, 2 or 4 to produce the peripheral enable. A CPU stage either passes that rate through unchanged or divides it by a further 4, so the CPU enable runs at main/1, /2, /4, /8 or /16. Both enables are one-cycle pulses in the main clock domain. Downstream logic qualifies its flops with them; this block does not gate any clock.

Two 8-bit control registers set the ratios. Software reaches them over a simple byte bus that can write a whole byte or set or clear one chosen bit. A prescale value of binary 11 is prohibited. Such a write leaves the register unchanged and raises an error flag for one cycle. A new ratio does not take effect at once. It is held until the current CPU period ends, so no enable interval is ever cut short.

Top module: `sysclk_prescaler`

## Requirements
- R1: After reset, both registers read 0x02 and cfg_err is low. Prescale field 10 and CPU bit 1 therefore give a peripheral rate of main/4 and a CPU rate of main/16.
- R2: The prescale register (rd_sel/wr_sel = 0) stores only bits 1:0. Bits 7:2 always read as zero.
- R3: The CPU register (rd_sel/wr_sel = 1) stores only bit 1. All other bits always read as zero.
- R4: periph_en pulses once every 1, 2 or 4 main cycles for active prescale field 00, 01 or 10. With field 00 it stays high continuously.
- R5: With the active CPU bit clear, cpu_en equals periph_en. With it set, cpu_en pulses once every 4 peripheral periods. Every cpu_en pulse coincides with a periph_en pulse.
- R6: A write that would leave 11 in the prescale field is ignored and the register keeps its value. cfg_err is high for exactly the cycle after each such write edge.
- R7: When wr_bitmode = 1, a write sets bit wr_bitidx of the selected register to wr_bitval and ignores wr_data. When wr_bitmode = 0, wr_data is written whole. The masks of R2 and R3 still apply.
- R8: The register contents are copied into the active ratio only in the last cycle of a CPU period. The first pulse at the new rate appears in the cycle right after that.
- R9: rd_data shows the register chosen by rd_sel in the same cycle, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | Write target: 0 prescale, 1 CPU |
| wr_bitmode | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_bitidx | input | 3 | Bit index for single-bit write |
| wr_bitval | input | 1 | Value for single-bit write |
| wr_data | input | 8 | Byte for byte write |
| rd_sel | input | 1 | Read target: 0 prescale, 1 CPU |
| rd_data | output | 8 | Read data of selected register |
| periph_en | output | 1 | Peripheral clock-enable pulse |
| cpu_en | output | 1 | CPU clock-enable pulse |
| cfg_err | output | 1 | One-cycle flag for a prohibited write |

## Verification
A corrupted register shows up on rd_data in the same cycle it is read. Within one CPU period it also shows up as a wrong pulse spacing once the value becomes active. A wrong phase counter or active ratio shifts periph_en or cpu_en in the very next cycle, so the bench compares both enables against its own phase model on every cycle. A missed or spurious prohibited-write check shows up one cycle later on cfg_err and on the read-back of the prescale register.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int REG_W      = 8;
  localparam int PRE_W      = 2;
  localparam int PRE_MAXLOG = 2;   // largest legal prescale exponent
  localparam int CPU_LOG    = 2;   // extra CPU stage exponent
  localparam int CNT_W      = PRE_MAXLOG + CPU_LOG;
  localparam int CPU_BIT    = 1;   // position of the CPU divide bit

  localparam logic [PRE_W-1:0] PRE_RST = 2'b10;
  localparam logic             CPU_RST = 1'b1;
  localparam logic [PRE_W-1:0] PRE_BAD = 2'b11;

  // Candidate register value after a byte or single-bit write.
  function automatic logic [REG_W-1:0] apply_write(
    input logic [REG_W-1:0] old_v,
    input logic             bitmode,
    input logic [2:0]       idx,
    input logic             val,
    input logic [REG_W-1:0] data
  );
    logic [REG_W-1:0] r;
    if (bitmode) begin
      r      = old_v;
      r[idx] = val;
    end else begin
      r = data;
    end
    return r;
  endfunction

  // Exponent of the CPU division: prescale plus optional CPU stage.
  function automatic logic [2:0] cpu_shift(input logic [PRE_W-1:0] pre, input logic cpu);
    return {1'b0, pre} + (cpu ? 3'(CPU_LOG) : 3'd0);
  endfunction

  function automatic logic [CNT_W-1:0] low_mask(input logic [2:0] sh);
    return CNT_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic             wr_bitmode,
  input  logic [2:0]       wr_bitidx,
  input  logic             wr_bitval,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic [PRE_W-1:0] pre_field,
  output logic             cpu_bit,
  output logic             bad_write,
  output logic             cfg_err
);
  logic [PRE_W-1:0] pre_q;
  logic             cpu_q;
  logic [REG_W-1:0] pre_view, cpu_view, pre_cand, cpu_cand;
  logic             pre_wr, cpu_wr;

  always_comb begin
    pre_view          = '0;
    pre_view[PRE_W-1:0] = pre_q;
    cpu_view          = '0;
    cpu_view[CPU_BIT] = cpu_q;
  end

  assign pre_cand  = apply_write(pre_view, wr_bitmode, wr_bitidx, wr_bitval, wr_data);
  assign cpu_cand  = apply_write(cpu_view, wr_bitmode, wr_bitidx, wr_bitval, wr_data);
  assign bad_write = wr_en && !wr_sel && (pre_cand[PRE_W-1:0] == PRE_BAD);
  assign pre_wr    = wr_en && !wr_sel && !bad_write;
  assign cpu_wr    = wr_en && wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= PRE_RST;
      cpu_q   <= CPU_RST;
      cfg_err <= 1'b0;
    end else begin
      if (pre_wr) pre_q <= pre_cand[PRE_W-1:0];
      if (cpu_wr) cpu_q <= cpu_cand[CPU_BIT];
      cfg_err <= bad_write;
    end
  end

  assign rd_data   = rd_sel ? cpu_view : pre_view;
  assign pre_field = pre_q;
  assign cpu_bit   = cpu_q;
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] req_pre,
  input  logic             req_cpu,
  output logic [PRE_W-1:0] act_pre,
  output logic             act_cpu,
  output logic             period_end,
  output logic             periph_en,
  output logic             cpu_en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last, pmask;

  assign last       = low_mask(cpu_shift(act_pre, act_cpu));
  assign pmask      = low_mask({1'b0, act_pre});
  assign period_end = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_pre <= PRE_RST;
      act_cpu <= CPU_RST;
    end else if (period_end) begin
      cnt     <= '0;
      act_pre <= req_pre;
      act_cpu <= req_cpu;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign periph_en = ((cnt & pmask) == '0);
  assign cpu_en    = (cnt == '0);
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic             wr_bitmode,
  input  logic [2:0]       wr_bitidx,
  input  logic             wr_bitval,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             periph_en,
  output logic             cpu_en,
  output logic             cfg_err
);
  logic [PRE_W-1:0] pre_field, act_pre;
  logic             cpu_bit, act_cpu, bad_write, period_end;

  sysclk_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_bitmode, .wr_bitidx, .wr_bitval, .wr_data,
    .rd_sel, .rd_data, .pre_field, .cpu_bit, .bad_write, .cfg_err
  );

  sysclk_divider u_div (
    .clk, .rst_n, .req_pre(pre_field), .req_cpu(cpu_bit),
    .act_pre, .act_cpu, .period_end, .periph_en, .cpu_en
  );
endmodule

// File: rtl/sysclk_prescaler_chk.sv
module sysclk_prescaler_chk
  import sysclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             periph_en,
  input logic             cpu_en,
  input logic             cfg_err,
  input logic [PRE_W-1:0] pre_field,
  input logic [PRE_W-1:0] act_pre,
  input logic             act_cpu,
  input logic             period_end
);
  AST_PRE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data[REG_W-1:PRE_W] == '0) && (rd_data[PRE_W-1:0] != PRE_BAD)); // R2
  AST_CPU_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> ((rd_data & ~(8'd1 << CPU_BIT)) == '0)); // R3
  AST_DIV1_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pre == '0) |-> periph_en); // R4
  AST_CPU_ON_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> periph_en); // R5
  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(wr_en && !wr_sel)); // R6
  AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(pre_field)); // R6
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_pre) && $stable(act_cpu)); // R8
endmodule

bind sysclk_prescaler sysclk_prescaler_chk u_chk (
  .clk, .rst_n, .wr_en, .wr_sel, .rd_sel, .rd_data, .periph_en, .cpu_en, .cfg_err,
  .pre_field, .act_pre, .act_cpu, .period_end
);

// File: tb/sysclk_prescaler_test.sv
module sysclk_prescaler_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, wr_bitmode = 1'b0, wr_bitval = 1'b0, rd_sel = 1'b0;
  logic [2:0] wr_bitidx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       periph_en, cpu_en, cfg_err;

  int total = 0, fails = 0;

  // bench model
  logic [1:0] m_pre;
  logic       m_cpu, m_err;
  logic [1:0] m_ap;
  logic       m_ac;
  int         m_ph;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_prescaler uut (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_bitmode, .wr_bitidx, .wr_bitval, .wr_data,
    .rd_sel, .rd_data, .periph_en, .cpu_en, .cfg_err
  );

  function automatic int period_of(logic [1:0] ap, logic ac);
    int p = 1;
    for (int i = 0; i < ap; i++) p = p * 2;
    if (ac) p = p * 4;
    return p;
  endfunction

  function automatic int pspan(logic [1:0] ap);
    return (ap == 2'd0) ? 1 : (ap == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle: apply inputs, compare outputs, advance model across one edge.
  task automatic cyc(input logic we, input logic sel, input logic bm, input logic [2:0] idx,
                     input logic bv, input logic [7:0] d, input logic rs, input string rtag);
    logic [7:0] cand, exp_rd;
    logic [1:0] n_pre;
    logic       n_cpu, n_err;
    wr_en = we; wr_sel = sel; wr_bitmode = bm; wr_bitidx = idx; wr_bitval = bv;
    wr_data = d; rd_sel = rs;
    #1;
    exp_rd = rs ? {6'd0, m_cpu, 1'b0} : {6'd0, m_pre};
    check(rd_data == exp_rd, rtag, rd_data, exp_rd);
    check(periph_en == ((m_ph % pspan(m_ap)) == 0), "R4,R8 periph_en", periph_en,
          (m_ph % pspan(m_ap)) == 0);
    check(cpu_en == (m_ph == 0), "R5,R8 cpu_en", cpu_en, m_ph == 0);
    check(cfg_err == m_err, "R6 cfg_err", cfg_err, m_err);
    n_pre = m_pre; n_cpu = m_cpu; n_err = 1'b0;
    if (we) begin
      if (bm) begin
        cand = sel ? {6'd0, m_cpu, 1'b0} : {6'd0, m_pre};
        cand[idx] = bv;
      end else cand = d;
      if (sel) n_cpu = cand[1];
      else if (cand[1:0] == 2'b11) n_err = 1'b1;
      else n_pre = cand[1:0];
    end
    @(posedge clk);
    if (m_ph == period_of(m_ap, m_ac) - 1) begin
      m_ap = m_pre; m_ac = m_cpu; m_ph = 0;
    end else m_ph++;
    m_pre = n_pre; m_cpu = n_cpu; m_err = n_err;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, i[0], "R9 read");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pre = 2'b10; m_cpu = 1'b1; m_err = 1'b0; m_ap = 2'b10; m_ac = 1'b1; m_ph = 0;
    #1;
    // R1 reset state
    check(rd_data == 8'h02, "R1 prescale reset", rd_data, 8'h02);
    rd_sel = 1'b1; #1;
    check(rd_data == 8'h02, "R1 cpu reset", rd_data, 8'h02);
    check(cfg_err == 1'b0, "R1 err reset", cfg_err, 0);
    #(CLK_PERIOD/2 - 2);
    @(negedge clk);
    m_ph = 1;  // one edge has passed since reset release
    idle(34);                                         // R1 rates /4 and /16
    cyc(1, 0, 0, 0, 0, 8'hFF, 0, "R9 read");          // R6 prohibited byte
    cyc(0, 0, 0, 0, 0, 0, 0, "R6 held after bad write");
    cyc(1, 0, 0, 0, 0, 8'hFD, 0, "R9 read");          // R2 masks upper bits -> 01
    cyc(0, 0, 0, 0, 0, 0, 0, "R2 upper bits zero");
    cyc(1, 1, 0, 0, 0, 8'hFF, 1, "R9 read");          // R3 only bit1
    cyc(0, 0, 0, 0, 0, 0, 1, "R3 only bit1 kept");
    cyc(1, 1, 1, 3'd1, 0, 8'hFF, 1, "R9 read");       // R7 clear bit1, data ignored
    cyc(0, 0, 0, 0, 0, 0, 1, "R7 bit clear");
    cyc(1, 0, 1, 3'd1, 1, 8'h00, 0, "R9 read");       // R7+R6 01 -> 11 prohibited
    cyc(0, 0, 0, 0, 0, 0, 0, "R7 bit set rejected");
    cyc(1, 0, 1, 3'd0, 0, 8'hFF, 0, "R9 read");       // R7 clear bit0 -> 00
    cyc(0, 0, 0, 0, 0, 0, 0, "R7 bit0 cleared");
    cyc(1, 0, 1, 3'd5, 1, 8'h00, 0, "R9 read");       // R2 set upper bit ignored
    cyc(0, 0, 0, 0, 0, 0, 0, "R2 upper set ignored");
    idle(40);                                         // R8 new ratio /1 continuous
    cyc(1, 1, 1, 3'd1, 1, 0, 1, "R9 read");           // R5 CPU stage on: /4
    idle(40);
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      cyc(($urandom % 6) == 0, 1'($urandom), 1'($urandom), 3'($urandom),
          1'($urandom), d, 1'($urandom), "R9 random read");
    end
    idle(40);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule